// File: doc/BRIEF.md
# Ternary-by-Integer Cyclic Convolution Multiplier

This block forms the product of two polynomials of degree N-1 in the ring of integer polynomials modulo X^N - 1. It reduces every coefficient of the result modulo q, where q = 2^QW. One operand is ternary: each of its coefficients is -1, 0 or +1. The other operand is a big polynomial whose coefficients lie in 0..q-1. Because X^N wraps to 1, result coefficient k is the sum over i of t_i * b_((k-i) mod N). N is a generic and need not be a power of two; the intended values are primes.

Software or a neighbouring engine first writes both operands one coefficient at a time through an indexed write port. A single-cycle start pulse then begins the computation. The core holds N accumulators that all update in the same cycle. In each of N steps, one ternary coefficient is applied to a rotated copy of the big operand: the core adds it, subtracts it, or leaves the accumulators unchanged. No multipliers are used.

The finished coefficients stream out in index order under a valid/ready handshake. The time from start to the first result is fixed and does not depend on operand values.

Top module: `ternconv_mul`

## Requirements
- R1: After a run, output coefficient k equals the sum over i in 0..N-1 of t_i * b_((k-i) mod N), for every k in 0..N-1.
- R2: Every output coefficient is that sum reduced modulo 2^QW. Negative sums and sums that overflow QW bits wrap to the residue in 0..2^QW-1.
- R3: Ternary coefficients use a 2-bit code: 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. The code 2'b10 has the same effect as 0.
- R4: While idle, a high ld_big_we writes ld_big into big coefficient ld_idx, and a high ld_tern_we writes ld_tern into ternary coefficient ld_idx. A write whose ld_idx is N or larger changes nothing.
- R5: Suppose start is sampled high at a rising edge while the block is idle. Then out_valid first reads high exactly N+2 rising edges later, whatever the operand values.
- R6: Results appear in index order 0, 1, …, N-1 on out_idx/out_data. The index advances only on a rising edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_data and out_idx hold.
- R7: out_last is high exactly while out_idx is N-1. After that coefficient is accepted, busy and out_valid are low from the next edge.
- R8: busy is high from the edge that accepts start until the last coefficient is accepted. While busy is high, operand writes and further start pulses have no effect on the results.
- R9: While rst is high at a rising edge, the block returns to idle, with busy and out_valid low. This holds in the middle of a run too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_big_we | input | 1 | Write enable for a big-operand coefficient |
| ld_tern_we | input | 1 | Write enable for a ternary-operand coefficient |
| ld_idx | input | IW = clog2(N) | Coefficient index shared by both write ports |
| ld_big | input | QW | Big coefficient value, 0..2^QW-1 |
| ld_tern | input | 2 | Ternary code (00 = 0, 01 = +1, 11 = -1, 10 = 0) |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | A run or its output stream is in progress |
| out_valid | output | 1 | out_data holds a result coefficient |
| out_ready | input | 1 | Consumer accepts the present coefficient |
| out_idx | output | IW | Index of the coefficient on out_data |
| out_data | output | QW | Result coefficient modulo 2^QW |
| out_last | output | 1 | Marks coefficient N-1 |

## Verification
A wrong rotation step in the shared operand register, or a wrong step counter, shifts or corrupts whole columns of the product. That error shows in out_data at the very first coefficient of the stream, N+2 cycles after start. A single accumulator that adds where it should subtract, or that mistreats the unused code 10, spoils only its own index. It therefore stays hidden until that index is handshaken out. Sequencing faults show sooner than data faults. A one-cycle error in the control path moves the rising edge of out_valid away from N+2. Writes leaking through during busy show up as mismatches in the stream of the same run.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    // two-bit code carried by each small coefficient
    typedef enum logic [1:0] {
        TC_ZERO  = 2'b00,
        TC_PLUS  = 2'b01,
        TC_BAD   = 2'b10,
        TC_MINUS = 2'b11
    } tcode_e;

    // action applied to every accumulator lane in one step
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10
    } mac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_SNAP,
        ST_STREAM
    } seq_state_e;

    // unused code 10 falls through to hold, same as a zero coefficient
    function automatic mac_op_e tcode_to_op(input logic [1:0] code);
        case (code)
            TC_PLUS:  return OP_ADD;
            TC_MINUS: return OP_SUB;
            default:  return OP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/ccm_operand_store.sv
module ccm_operand_store
    import ccm_pkg::*;
#(
    parameter int unsigned N  = 11,
    parameter int unsigned QW = 8,
    parameter int unsigned IW = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_allow,
    input  logic                   big_we,
    input  logic                   tern_we,
    input  logic [IW-1:0]          wr_idx,
    input  logic [QW-1:0]          big_din,
    input  logic [1:0]             tern_din,
    output logic [N-1:0][QW-1:0]   big_q,
    output logic [N-1:0][1:0]      tern_q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [QW-1:0] big_r;
        logic [1:0]    tern_r;
        logic          hit;

        assign hit = wr_allow && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                big_r  <= '0;
                tern_r <= TC_ZERO;
            end else begin
                if (hit && big_we)  big_r  <= big_din;
                if (hit && tern_we) tern_r <= tern_din;
            end
        end

        assign big_q[g]  = big_r;
        assign tern_q[g] = tern_r;
    end

    // R8: operands are frozen while the sequencer is busy
    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_allow |=> $stable(big_q) && $stable(tern_q));

endmodule

// File: rtl/ccm_mac_array.sv
module ccm_mac_array
    import ccm_pkg::*;
#(
    parameter int unsigned N  = 11,
    parameter int unsigned QW = 8,
    parameter int unsigned IW = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch,
    input  logic                   feed,
    input  logic [IW-1:0]          step,
    input  logic [N-1:0][QW-1:0]   big_q,
    input  logic [N-1:0][1:0]      tern_q,
    output logic [N-1:0][QW-1:0]   acc_q
);

    logic [N-1:0][QW-1:0] rot_q;
    logic [N-1:0][QW-1:0] vec_q;
    mac_op_e              op_q;
    logic                 pv_q;

    // stage 1: pick this step's small coefficient, snapshot the rotated operand
    always_ff @(posedge clk) begin
        if (rst) begin
            rot_q <= '0;
            vec_q <= '0;
            op_q  <= OP_HOLD;
            pv_q  <= 1'b0;
        end else if (launch) begin
            rot_q <= big_q;
            pv_q  <= 1'b0;
        end else if (feed) begin
            vec_q <= rot_q;
            op_q  <= tcode_to_op(tern_q[step]);
            pv_q  <= 1'b1;
            rot_q <= {rot_q[N-2:0], rot_q[N-1]};
        end else begin
            pv_q  <= 1'b0;
        end
    end

    // stage 2: N lanes, truncation to QW bits is the modulo-q reduction
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [QW-1:0] acc_r;

        always_ff @(posedge clk) begin
            if (rst || launch) begin
                acc_r <= '0;
            end else if (pv_q) begin
                case (op_q)
                    OP_ADD:  acc_r <= acc_r + vec_q[g];
                    OP_SUB:  acc_r <= acc_r - vec_q[g];
                    default: acc_r <= acc_r;
                endcase
            end
        end

        assign acc_q[g] = acc_r;
    end

    // R3: a zero or unused code leaves every lane untouched
    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (rst)
        pv_q && (op_q == OP_HOLD) && !launch |=> $stable(acc_q));

endmodule

// File: rtl/ccm_seq_ctrl.sv
module ccm_seq_ctrl
    import ccm_pkg::*;
#(
    parameter int unsigned N  = 11,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          out_ready,
    output logic          launch,
    output logic          feed,
    output logic [IW-1:0] step,
    output logic          busy,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic          out_last
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);
    localparam int unsigned   LW   = IW + 2;

    seq_state_e    st_q;
    logic [IW-1:0] step_q;
    logic [IW-1:0] oidx_q;
    logic          fire;

    assign launch    = (st_q == ST_IDLE) && start;
    assign feed      = (st_q == ST_RUN);
    assign busy      = (st_q != ST_IDLE);
    assign out_valid = (st_q == ST_STREAM);
    assign out_last  = out_valid && (oidx_q == LAST);
    assign out_idx   = oidx_q;
    assign step      = step_q;
    assign fire      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            oidx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_RUN;
                        step_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_q == LAST) st_q <= ST_FLUSH;
                    else                step_q <= step_q + 1'b1;
                end
                ST_FLUSH: st_q <= ST_SNAP;
                ST_SNAP: begin
                    st_q   <= ST_STREAM;
                    oidx_q <= '0;
                end
                ST_STREAM: begin
                    if (fire) begin
                        if (oidx_q == LAST) st_q <= ST_IDLE;
                        else                oidx_q <= oidx_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // edge counter for the latency check
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst || launch)
            lat_q <= '0;
        else if (st_q == ST_RUN || st_q == ST_FLUSH || st_q == ST_SNAP)
            lat_q <= lat_q + 1'b1;
    end

    // R5: the first result appears a fixed N+2 edges after start
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> lat_q == LW'(N + 2));

endmodule

// File: rtl/ternconv_mul.sv
module ternconv_mul
    import ccm_pkg::*;
#(
    parameter int unsigned N  = 11,
    parameter int unsigned QW = 8,
    localparam int unsigned IW = (N < 2) ? 1 : $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_big_we,
    input  logic          ld_tern_we,
    input  logic [IW-1:0] ld_idx,
    input  logic [QW-1:0] ld_big,
    input  logic [1:0]    ld_tern,
    input  logic          start,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [IW-1:0] out_idx,
    output logic [QW-1:0] out_data,
    output logic          out_last
);

    logic [N-1:0][QW-1:0] big_q;
    logic [N-1:0][1:0]    tern_q;
    logic [N-1:0][QW-1:0] acc_q;
    logic                 launch;
    logic                 feed;
    logic [IW-1:0]        step;

    ccm_operand_store #(.N(N), .QW(QW), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_allow (!busy),
        .big_we   (ld_big_we),
        .tern_we  (ld_tern_we),
        .wr_idx   (ld_idx),
        .big_din  (ld_big),
        .tern_din (ld_tern),
        .big_q    (big_q),
        .tern_q   (tern_q)
    );

    ccm_seq_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .out_ready (out_ready),
        .launch    (launch),
        .feed      (feed),
        .step      (step),
        .busy      (busy),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_last  (out_last)
    );

    ccm_mac_array #(.N(N), .QW(QW), .IW(IW)) u_mac (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .feed   (feed),
        .step   (step),
        .big_q  (big_q),
        .tern_q (tern_q),
        .acc_q  (acc_q)
    );

    assign out_data = acc_q[out_idx];

    // R6: a stalled coefficient stays put
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx));

    // R6: an accepted non-final coefficient is followed by the next index
    assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && (out_idx == $past(out_idx) + 1'b1));

    // R7: accepting the final coefficient ends the run
    assert_done_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !busy && !out_valid);

    // R9: first cycle after reset is quiet
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !out_valid);

endmodule

// File: tb/ternconv_mul_tb_top.sv
`timescale 1ns/1ps
module ternconv_mul_tb_top;

    localparam int unsigned N     = 11;
    localparam int unsigned QW    = 8;
    localparam int unsigned IW    = $clog2(N);
    localparam int          QMASK = (1 << QW) - 1;

    // stimulus table: {mode, seed, stall}
    // mode 0 random legal ternary, 1 all zero, 2 all minus one,
    // 3 random codes incl. 10, 4 single +1, 5 all +1 with big all q-1
    localparam int unsigned NVEC = 7;
    localparam int unsigned VEC [NVEC][3] = '{
        '{0, 17, 0}, '{1, 5, 0}, '{2, 9, 1}, '{3, 33, 0},
        '{4, 3, 1},  '{5, 0, 0}, '{0, 101, 1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_big_we = 1'b0, ld_tern_we = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [QW-1:0] ld_big = '0;
    logic [1:0]    ld_tern = '0;
    logic          start = 1'b0, out_ready = 1'b0;
    logic          busy, out_valid, out_last;
    logic [IW-1:0] out_idx;
    logic [QW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int big_m [N];
    int tern_m [N];
    int exp_m [N];
    int unsigned seed_s;

    always #4 clk = ~clk;

    ternconv_mul #(.N(N), .QW(QW)) dut_i (
        .clk(clk), .rst(rst), .ld_big_we(ld_big_we), .ld_tern_we(ld_tern_we),
        .ld_idx(ld_idx), .ld_big(ld_big), .ld_tern(ld_tern), .start(start),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_idx(out_idx), .out_data(out_data), .out_last(out_last)
    );

    function automatic int unsigned next_rand();
        seed_s = seed_s * 1103515245 + 12345;
        return (seed_s >> 16) & 32'h7fff;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // direct O(N^2) reference: 01 -> +1, 11 -> -1, else 0
    task automatic compute_ref();
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int i = 0; i < N; i++) begin
                int b = big_m[(k - i + N) % N];
                if (tern_m[i] == 1) s += b;
                else if (tern_m[i] == 3) s -= b;
            end
            exp_m[k] = s & QMASK;
        end
    endtask

    task automatic build(input int unsigned mode, input int unsigned sd);
        seed_s = sd + 7;
        for (int i = 0; i < N; i++) begin
            int unsigned r = next_rand();
            big_m[i] = int'(next_rand()) & QMASK;
            case (mode)
                0: tern_m[i] = (r % 3 == 0) ? 0 : ((r % 3 == 1) ? 1 : 3);
                1: tern_m[i] = 0;
                2: tern_m[i] = 3;
                3: tern_m[i] = int'(r % 4);
                4: tern_m[i] = (i == int'(sd % N)) ? 1 : 0;
                default: begin
                    tern_m[i] = 1;
                    big_m[i]  = QMASK;
                end
            endcase
        end
        compute_ref();
    endtask

    task automatic load_ops();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_big_we = 1'b1; ld_tern_we = 1'b1;
            ld_idx = IW'(i); ld_big = QW'(big_m[i]); ld_tern = 2'(tern_m[i]);
        end
        // R4: index beyond N-1 must change nothing
        @(negedge clk);
        ld_idx = IW'(N); ld_big = '1; ld_tern = 2'b01;
        @(negedge clk);
        ld_big_we = 1'b0; ld_tern_we = 1'b0;
    endtask

    task automatic run_and_check(input bit stall, input bit meddle, input string tag);
        int lat = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        while (!out_valid && lat < 64) begin
            if (meddle && lat < int'(N)) begin
                // R8: writes and start while busy must be ignored
                ld_big_we = 1'b1; ld_tern_we = 1'b1; start = 1'b1;
                ld_idx = IW'(lat % N); ld_big = QW'(lat * 37 + 5); ld_tern = 2'b11;
            end else begin
                ld_big_we = 1'b0; ld_tern_we = 1'b0; start = 1'b0;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        ld_big_we = 1'b0; ld_tern_we = 1'b0; start = 1'b0;
        check(lat == int'(N) + 2, "R5 latency", lat, int'(N) + 2);
        for (int k = 0; k < N; k++) begin
            if (stall && (k % 3 == 1)) begin
                logic [QW-1:0] held = out_data;
                out_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check(out_valid && out_data == held && out_idx == IW'(k),
                      "R6 stall hold", int'(out_data), int'(held));
            end
            out_ready = 1'b1;
            check(out_valid && out_data == QW'(exp_m[k]), tag, int'(out_data), exp_m[k]);
            check(out_idx == IW'(k), "R6 order", int'(out_idx), k);
            check(out_last == (k == int'(N) - 1), "R7 last flag", int'(out_last), int'(k == int'(N) - 1));
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
        end
        check(!busy && !out_valid, "R7 idle after last", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !out_valid, "R9 reset state", int'(busy) + int'(out_valid), 0);

        for (int v = 0; v < int'(NVEC); v++) begin
            string tag;
            build(VEC[v][0], VEC[v][1]);
            load_ops();
            case (VEC[v][0])
                3: tag = "R3 data with code 10";
                2: tag = "R2 data negative wrap";
                5: tag = "R2 data overflow wrap";
                default: tag = "R1 data";
            endcase
            run_and_check(VEC[v][2] != 0, 1'b0, tag);
        end

        // R8: interference during a run
        build(0, 55);
        load_ops();
        run_and_check(1'b0, 1'b1, "R8 data after ignored writes");

        // R4: operands from the run above survive an out-of-range write pass
        @(negedge clk);
        ld_big_we = 1'b1; ld_tern_we = 1'b1; ld_idx = IW'(N + 1); ld_big = '1; ld_tern = 2'b11;
        @(negedge clk);
        ld_big_we = 1'b0; ld_tern_we = 1'b0;
        run_and_check(1'b0, 1'b0, "R4 data after out-of-range write");

        // R9: reset in the middle of a run
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !out_valid, "R9 mid-run reset", int'(busy), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule